// File: doc/BRIEF.md
# Piecewise-Linear Template Weight Generator

This block produces the coupling weights of one template row for a cellular neural network cell update, for templates whose weights are piecewise-linear functions of the difference between the cell being updated and each of its neighbours. Each beat on the input stream carries the centre cell state, the three neighbour states of one template row and the row index. For each of the three template columns the block subtracts the neighbour from the centre. The top bits of that difference select a segment, and a per-column pair of tables supplies that segment's slope and offset. The weight is the slope times the difference, rescaled to the template fraction format, plus the offset, saturated to the template width.

The three weights leave on an output stream together with the neighbour states and the row index, delayed by the same number of stages so that a downstream state-update unit sees each weight next to the value it multiplies. The stream has a fixed depth of four stages. The whole pipeline advances whenever the output slot is empty or is being taken. When the output is held (`out_valid` high, `out_ready` low) every stage freezes and `in_ready` drops. A host loads the slope and offset tables through a plain write port while the stream is idle.

Top module: `pwl_weight_gen`

## Requirements
- R1: For each column the difference is centre minus neighbour, both taken as STATE_W-bit two's complement and formed in STATE_W+1 bits. The segment index is the top SEG_BITS bits of that difference read as an unsigned number. The table address is row * 2^SEG_BITS + segment, for rows 0 to ROWS-1.
- R2: Each weight equals ((difference * slope) arithmetically shifted right by STATE_FRAC) + offset. Slope and offset are TPL_W-bit two's complement values with TPL_FRAC fraction bits, and the difference carries STATE_FRAC fraction bits.
- R3: A weight beyond the TPL_W-bit signed range is clipped to the largest or smallest representable value.
- R4: Column c (0, 1, 2) reads only its own slope and offset tables. Column c's weight is the field out_weight[c*TPL_W +: TPL_W], and its neighbour is in_nbr[c*STATE_W +: STATE_W].
- R5: With out_ready held high, a beat accepted at one clock edge shows its result on the output four cycles later, and a new beat can be accepted every cycle.
- R6: While out_valid is high and out_ready is low, out_valid stays high, all output fields stay unchanged and in_ready is low.
- R7: out_nbr and out_row equal the in_nbr and in_row of the beat whose weights are presented, and beats leave in acceptance order.
- R8: During and right after reset, out_valid is low and in_ready is high.
- R9: A table write (tbl_we high with tbl_col, tbl_addr, tbl_slope, tbl_offset) replaces that column's slope and offset at that address, and the new values are used by beats accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat taken at this edge when in_valid is high |
| in_row | input | ROW_W | Template row index, 0 to ROWS-1 |
| in_centre | input | STATE_W | Centre cell state, two's complement |
| in_nbr | input | COLS*STATE_W | Neighbour states, column c in bits c*STATE_W upward |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_weight | output | COLS*TPL_W | Saturated weights, column c in bits c*TPL_W upward |
| out_nbr | output | COLS*STATE_W | Neighbour states aligned with the weights |
| out_row | output | ROW_W | Row index aligned with the weights |
| tbl_we | input | 1 | Table write strobe |
| tbl_col | input | COL_W | Column whose tables are written |
| tbl_addr | input | ADDR_W | Table address, row * 2^SEG_BITS + segment |
| tbl_slope | input | TPL_W | Slope value to store |
| tbl_offset | input | TPL_W | Offset value to store |

## Verification
A wrong segment address, a bad shift or a lost sign extension shows as a wrong weight on the output handshake of the affected beat, four cycles after it was taken when the output is not held. A stage that advances during a stall, or a delay line one stage off from the arithmetic path, shows as a changed field on the cycle after a stall starts, or as a neighbour value on the same handshake that does not belong to its weights. A dropped or duplicated beat shows as an output with no matching input, or as a missing output once the stream has drained.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int STATE_W_D    = 10;
  localparam int STATE_FRAC_D = 6;
  localparam int TPL_W_D      = 9;
  localparam int TPL_FRAC_D   = 7;
  localparam int SEG_BITS_D   = 2;
  localparam int ROWS_D       = 3;
  localparam int COLS_D       = 3;
  // stage count: difference, table read, product, sum with clip
  localparam int PIPE_LAT     = 4;
endpackage

// File: rtl/pwl_seg_table.sv
module pwl_seg_table #(
  parameter int TPL_W  = 9,
  parameter int ADDR_W = 4,
  parameter int COL_W  = 2,
  parameter int COL_ID = 0
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [TPL_W-1:0]  slope_q,
  output logic signed [TPL_W-1:0]  offset_q,
  input  logic                     wr_en,
  input  logic [COL_W-1:0]         wr_col,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [TPL_W-1:0]  wr_slope,
  input  logic signed [TPL_W-1:0]  wr_offset
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [TPL_W-1:0] slope_mem  [DEPTH];
  logic signed [TPL_W-1:0] offset_mem [DEPTH];
  logic                    mine;

  assign mine = wr_en && (wr_col == COL_W'(COL_ID));

  always_ff @(posedge clk) begin
    if (mine) begin
      slope_mem[wr_addr]  <= wr_slope;
      offset_mem[wr_addr] <= wr_offset;
    end
    if (rd_en) begin
      slope_q  <= slope_mem[rd_addr];
      offset_q <= offset_mem[rd_addr];
    end
  end
endmodule

// File: rtl/pwl_mac.sv
module pwl_mac #(
  parameter int TPL_W  = 9,
  parameter int DIFF_W = 11,
  parameter int SHIFT  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DIFF_W-1:0] diff,
  input  logic signed [TPL_W-1:0]  slope,
  input  logic signed [TPL_W-1:0]  offset,
  output logic signed [TPL_W-1:0]  weight
);
  localparam int PW = DIFF_W + TPL_W;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HI = (SW'(1) <<< (TPL_W - 1)) - SW'(1);
  localparam logic signed [SW-1:0] LO = ~HI;

  logic signed [PW-1:0]    prod_q;
  logic signed [TPL_W-1:0] off_q;
  logic signed [PW-1:0]    scaled;
  logic signed [SW-1:0]    sum;

  always_comb begin
    scaled = prod_q >>> SHIFT;
    sum = $signed({scaled[PW-1], scaled}) +
          $signed({{(SW-TPL_W){off_q[TPL_W-1]}}, off_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      off_q  <= '0;
      weight <= '0;
    end else if (en) begin
      prod_q <= PW'(diff) * PW'(slope);
      off_q  <= offset;
      if (sum > HI)      weight <= HI[TPL_W-1:0];
      else if (sum < LO) weight <= LO[TPL_W-1:0];
      else               weight <= sum[TPL_W-1:0];
    end
  end
endmodule

// File: rtl/pwl_delay.sv
module pwl_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else if (en) begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/pwl_weight_gen.sv
module pwl_weight_gen
  import pwl_pkg::*;
#(
  parameter int STATE_W    = STATE_W_D,
  parameter int STATE_FRAC = STATE_FRAC_D,
  parameter int TPL_W      = TPL_W_D,
  parameter int TPL_FRAC   = TPL_FRAC_D,
  parameter int SEG_BITS   = SEG_BITS_D,
  parameter int ROWS       = ROWS_D,
  parameter int COLS       = COLS_D,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int COL_W     = $clog2(COLS),
  localparam int ADDR_W    = ROW_W + SEG_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ROW_W-1:0]         in_row,
  input  logic [STATE_W-1:0]       in_centre,
  input  logic [COLS*STATE_W-1:0]  in_nbr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [COLS*TPL_W-1:0]    out_weight,
  output logic [COLS*STATE_W-1:0]  out_nbr,
  output logic [ROW_W-1:0]         out_row,
  input  logic                     tbl_we,
  input  logic [COL_W-1:0]         tbl_col,
  input  logic [ADDR_W-1:0]        tbl_addr,
  input  logic [TPL_W-1:0]         tbl_slope,
  input  logic [TPL_W-1:0]         tbl_offset
);
  localparam int DIFF_W = STATE_W + 1;
  localparam int PASS_W = ROW_W + COLS * STATE_W;
  // weights carry TPL_FRAC fraction bits; product rescale removes STATE_FRAC
  localparam int OUT_FRAC = TPL_FRAC;

  logic              adv;
  logic [PASS_W-1:0] pass_q;

  // single advance enable: every stage moves unless the output is held
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  pwl_delay #(.W(1), .DEPTH(PIPE_LAT)) u_valid_line (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(in_valid), .q(out_valid)
  );

  pwl_delay #(.W(PASS_W), .DEPTH(PIPE_LAT)) u_pass_line (
    .clk(clk), .rst_n(rst_n), .en(adv), .d({in_row, in_nbr}), .q(pass_q)
  );

  assign out_row = pass_q[PASS_W-1 -: ROW_W];
  assign out_nbr = pass_q[COLS*STATE_W-1:0];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [STATE_W-1:0]       nbr;
    logic signed [DIFF_W-1:0] diff_c;
    logic signed [DIFF_W-1:0] diff_s0;
    logic signed [DIFF_W-1:0] diff_s1;
    logic [ADDR_W-1:0]        addr_s0;
    logic signed [TPL_W-1:0]  slope_s1;
    logic signed [TPL_W-1:0]  offset_s1;
    logic signed [TPL_W-1:0]  weight_c;

    assign nbr    = in_nbr[c*STATE_W +: STATE_W];
    assign diff_c = $signed({in_centre[STATE_W-1], in_centre}) -
                    $signed({nbr[STATE_W-1], nbr});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        diff_s0 <= '0;
        diff_s1 <= '0;
        addr_s0 <= '0;
      end else if (adv) begin
        diff_s0 <= diff_c;
        addr_s0 <= {in_row, diff_c[DIFF_W-1 -: SEG_BITS]};
        diff_s1 <= diff_s0;
      end
    end

    pwl_seg_table #(.TPL_W(TPL_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .COL_ID(c)) u_table (
      .clk(clk), .rd_en(adv), .rd_addr(addr_s0),
      .slope_q(slope_s1), .offset_q(offset_s1),
      .wr_en(tbl_we), .wr_col(tbl_col), .wr_addr(tbl_addr),
      .wr_slope(tbl_slope), .wr_offset(tbl_offset)
    );

    pwl_mac #(.TPL_W(TPL_W), .DIFF_W(DIFF_W), .SHIFT(STATE_FRAC)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .diff(diff_s1), .slope(slope_s1), .offset(offset_s1), .weight(weight_c)
    );

    assign out_weight[c*TPL_W +: TPL_W] = weight_c;
  end

  if (OUT_FRAC < 0) begin : g_bad_frac
    $error("template fraction bits must not be negative");
  end
endmodule

// File: rtl/pwl_weight_gen_chk.sv
module pwl_weight_gen_chk
  import pwl_pkg::*;
#(
  parameter int OW = COLS_D * TPL_W_D,
  parameter int NW = COLS_D * STATE_W_D,
  parameter int RW = $clog2(ROWS_D)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_weight,
  input logic [NW-1:0] out_nbr,
  input logic [RW-1:0] out_row
);
  logic [3:0] in_flight;
  logic       in_hs, out_hs;

  assign in_hs  = in_valid && in_ready;
  assign out_hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= '0;
    else if (in_hs && !out_hs) in_flight <= in_flight + 4'd1;
    else if (!in_hs && out_hs) in_flight <= in_flight - 4'd1;
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_weight) && $stable(out_nbr) && $stable(out_row))); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && in_ready)); // R8

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_flight != 4'd0)); // R5

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= 4'(PIPE_LAT)); // R5

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight == 4'd0) |-> in_ready); // R6
endmodule

bind pwl_weight_gen pwl_weight_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_weight(out_weight),
  .out_nbr(out_nbr), .out_row(out_row)
);

// File: tb/pwl_weight_gen_test.sv
module pwl_weight_gen_test;
  import pwl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SW   = STATE_W_D;
  localparam int TW   = TPL_W_D;
  localparam int NC   = COLS_D;
  localparam int SEGB = SEG_BITS_D;
  localparam int FR   = STATE_FRAC_D;
  localparam int RW   = $clog2(ROWS_D);
  localparam int CW   = $clog2(COLS_D);
  localparam int AW   = RW + SEGB;
  localparam int NA   = 1 << AW;
  localparam int PW   = RW + NC * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [RW-1:0] in_row = '0;
  logic [SW-1:0] in_centre = '0;
  logic [NC*SW-1:0] in_nbr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NC*TW-1:0] out_weight;
  logic [NC*SW-1:0] out_nbr;
  logic [RW-1:0] out_row;
  logic tbl_we = 1'b0;
  logic [CW-1:0] tbl_col = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [TW-1:0] tbl_slope = '0;
  logic [TW-1:0] tbl_offset = '0;

  pwl_weight_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_centre(in_centre), .in_nbr(in_nbr),
    .out_valid(out_valid), .out_ready(out_ready), .out_weight(out_weight),
    .out_nbr(out_nbr), .out_row(out_row), .tbl_we(tbl_we), .tbl_col(tbl_col),
    .tbl_addr(tbl_addr), .tbl_slope(tbl_slope), .tbl_offset(tbl_offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int slope_t [NC][NA];
  int off_t   [NC][NA];

  int exp_w [$];
  logic [PW-1:0] exp_p [$];
  int exp_cyc [$];
  bit exp_hold [$];
  string exp_tag [$];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit hold_ready = 1'b1;
  string cur_tag = "R2";
  bit prev_stall = 1'b0;
  logic [NC*TW-1:0] prev_w;
  logic [PW-1:0] prev_p;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int sx(logic [SW-1:0] v);
    return v[SW-1] ? int'(v) - (1 << SW) : int'(v);
  endfunction

  // reference weight from the requirements (R1 address, R2 formula, R3 clip)
  function automatic int ref_weight(int c, int row, int centre, int nbr);
    int d, u, seg, addr, p, s, hi;
    d    = centre - nbr;
    u    = d & ((1 << (SW + 1)) - 1);
    seg  = u >> (SW + 1 - SEGB);
    addr = row * (1 << SEGB) + seg;
    p    = d * slope_t[c][addr];
    s    = (p >>> FR) + off_t[c][addr];
    hi   = (1 << (TW - 1)) - 1;
    if (s > hi) s = hi;
    if (s < -hi - 1) s = -hi - 1;
    return s;
  endfunction

  // monitor: sample 2 time units after the falling edge, compare on every clock
  always @(negedge clk) begin
    #2;
    cyc++;
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R6", "valid dropped while held", longint'(out_valid), 1);
        chk(out_weight == prev_w, "R6", "weights changed while held", longint'(out_weight), longint'(prev_w));
        chk({out_row, out_nbr} == prev_p, "R6", "pass data changed while held",
            longint'({out_row, out_nbr}), longint'(prev_p));
      end
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R6", "in_ready during hold", longint'(in_ready), 0);
      if (in_valid && in_ready) begin
        for (int c = 0; c < NC; c++)
          exp_w.push_back(ref_weight(c, int'(in_row), sx(in_centre), sx(in_nbr[c*SW +: SW])));
        exp_p.push_back({in_row, in_nbr});
        exp_cyc.push_back(cyc);
        exp_hold.push_back(hold_ready);
        exp_tag.push_back(cur_tag);
      end
      if (out_valid && out_ready) begin
        if (exp_cyc.size() == 0) begin
          chk(1'b0, "R5", "output with no accepted input", 1, 0);
        end else begin
          string tg;
          int c0;
          bit h;
          tg = exp_tag.pop_front();
          c0 = exp_cyc.pop_front();
          h  = exp_hold.pop_front();
          for (int c = 0; c < NC; c++) begin
            int e, a;
            e = exp_w.pop_front();
            a = int'($signed(out_weight[c*TW +: TW]));
            chk(a == e, tg, $sformatf("weight column %0d", c), a, e);
          end
          chk({out_row, out_nbr} == exp_p.pop_front(), "R7", "aligned row and neighbours",
              longint'({out_row, out_nbr}), 0);
          if (h && hold_ready)
            chk(cyc - c0 == PIPE_LAT, "R5", "latency in cycles", cyc - c0, PIPE_LAT);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_w = out_weight;
      prev_p = {out_row, out_nbr};
    end
  end

  always @(negedge clk) begin
    out_ready = hold_ready ? 1'b1 : ($urandom_range(0, 2) != 0);
  end

  // called right after a falling edge; returns right after the falling edge that follows acceptance
  task automatic send(int row, logic [SW-1:0] ce, logic [NC*SW-1:0] nb);
    bit took;
    in_valid  = 1'b1;
    in_row    = RW'(row);
    in_centre = ce;
    in_nbr    = nb;
    forever begin
      #1;
      took = in_ready;
      @(negedge clk);
      if (took) break;
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_tbl(int col, int addr, int s, int o);
    tbl_we     = 1'b1;
    tbl_col    = CW'(col);
    tbl_addr   = AW'(addr);
    tbl_slope  = TW'(s);
    tbl_offset = TW'(o);
    slope_t[col][addr] = s;
    off_t[col][addr]   = o;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (exp_cyc.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int rnd_tpl();
    return int'($urandom_range(0, (1 << TW) - 1)) - (1 << (TW - 1));
  endfunction

  task automatic send_random();
    logic [NC*SW-1:0] nb;
    for (int c = 0; c < NC; c++) nb[c*SW +: SW] = SW'($urandom);
    send(int'($urandom_range(0, ROWS_D - 1)), SW'($urandom), nb);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NC*SW-1:0] nb;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8", "out_valid in reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", longint'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(out_valid == 1'b0, "R8", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", longint'(in_ready), 1);
    @(negedge clk);

    // R4: every column gets its own random tables
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < NA; a++)
        write_tbl(c, a, rnd_tpl(), rnd_tpl());

    // R5: back to back with the output always taken
    hold_ready = 1'b1;
    cur_tag = "R1/R2/R4";
    repeat (3) @(negedge clk);
    for (int i = 0; i < 24; i++) send_random();
    drain();

    // R6, R7: random back-pressure and input gaps
    hold_ready = 1'b0;
    for (int i = 0; i < 400; i++) begin
      send_random();
      if ($urandom_range(0, 3) == 0) idle();
    end
    drain();
    hold_ready = 1'b1;

    // R9: rewrite some entries, then use them
    cur_tag = "R9";
    for (int i = 0; i < 12; i++)
      write_tbl(int'($urandom_range(0, NC - 1)), int'($urandom_range(0, ROWS_D * (1 << SEGB) - 1)),
                rnd_tpl(), rnd_tpl());
    for (int i = 0; i < 80; i++) send_random();
    drain();

    // R3: extreme slopes and offsets on row 2 drive both clip limits
    for (int a = 2 * (1 << SEGB); a < 3 * (1 << SEGB); a++) begin
      write_tbl(0, a, (1 << (TW - 1)) - 1, (1 << (TW - 1)) - 1);
      write_tbl(1, a, -(1 << (TW - 1)), -(1 << (TW - 1)));
      write_tbl(2, a, 0, 100);
    end
    cur_tag = "R3";
    for (int c = 0; c < NC; c++) nb[c*SW +: SW] = SW'(-(1 << (SW - 1)));
    send(2, SW'((1 << (SW - 1)) - 1), nb);
    for (int c = 0; c < NC; c++) nb[c*SW +: SW] = SW'((1 << (SW - 1)) - 1);
    send(2, SW'(-(1 << (SW - 1))), nb);
    for (int i = 0; i < 30; i++) begin
      for (int c = 0; c < NC; c++) nb[c*SW +: SW] = SW'($urandom);
      send(2, SW'($urandom), nb);
    end
    drain();

    chk(exp_cyc.size() == 0, "R7", "beats left undelivered", exp_cyc.size(), 0);
    finish_run();
  end
endmodule